// File: doc/BRIEF.md
# I2C Master Read Engine

This block is the receive side of a two-wire bus master. A host processor starts a transfer by pulsing a control write with the start bit set. The engine then puts a START condition on the bus and shifts out the 7-bit target address followed by a read bit of 1. It samples the target's acknowledge and then clocks in data bytes that the target drives on SDA. The engine drives SCL for every bit. Both bus lines are open-drain: the engine only ever pulls a line low through an output-enable, and it reads SDA back through an input.

When the eighth data bit has been sampled, the engine loads the received byte and raises an acknowledge-request flag and the interrupt. It does this before the ninth clock and keeps SCL low until the host answers. The host answers with a control write. The acknowledge bit of that write picks ACK (SDA pulled low) or NACK (SDA released), and the stop bit asks for a STOP once the acknowledge clock has finished. Without a stop request the next byte follows at once, so a transfer may hold any number of bytes.

If the target does not acknowledge its address, the engine flags it, raises the interrupt and holds the bus until the host requests a STOP. A write to the data register during a transfer moves the engine into transmit mode, which shows on a status output.

Top module: `i2c_rx_master`

## Requirements
- R1: After reset both line enables are off and busy, ackReq, addrNack, txMode and irq are all 0.
- R2: A control write with ctrlSta=1 while idle produces a START (SDA falls while SCL is high) and asserts busy. It then sends slaveAddr MSB first followed by a read bit of 1, nine bits in all counting the acknowledge slot.
- R3: If SDA is high when the address acknowledge slot is sampled, addrNack and irq go to 1 and ackReq stays 0. SCL is held low until a control write with ctrlSto=1, which clears addrNack and produces a STOP.
- R4: Data bits are sampled while SCL is high and shifted in MSB first. rxData takes the whole byte in the same cycle that ackReq rises, and it does not change while ackReq stays set.
- R5: ackReq and irq go to 1 after the eighth data bit and before the acknowledge clock. SCL stays pulled low for as long as ackReq is 1.
- R6: A control write while ackReq is 1 clears ackReq on the next cycle. During the acknowledge clock that follows, SDA is pulled low if ctrlAck=1 and left released if ctrlAck=0.
- R7: A control write with ctrlSto=0 starts the next byte right after the acknowledge clock, so any number of bytes can be received in one transfer.
- R8: With ctrlSto=1 the engine produces a STOP (SDA rises while SCL is high) after the acknowledge clock. busy stays 1 until that STOP is complete.
- R9: Every SCL high phase of a data bit lasts HALF_DIV clock cycles.
- R10: A dataWr pulse while busy sets txMode, and a dataWr pulse while idle leaves it at 0. txMode is cleared when the transfer ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWr | input | 1 | Control register write strobe |
| ctrlSta | input | 1 | Start request bit of the control write |
| ctrlSto | input | 1 | Stop request bit of the control write |
| ctrlAck | input | 1 | Acknowledge value: 1 sends ACK, 0 sends NACK |
| slaveAddr | input | 7 | Target address, captured at start |
| dataWr | input | 1 | Data register write strobe |
| sdaIn | input | 1 | Sampled SDA line level |
| sclOe | output | 1 | Pull SCL low when 1 |
| sdaOe | output | 1 | Pull SDA low when 1 |
| rxData | output | 8 | Last received byte |
| ackReq | output | 1 | Byte received, acknowledge choice pending |
| addrNack | output | 1 | Target did not acknowledge its address |
| busy | output | 1 | Transfer in progress from START through STOP |
| txMode | output | 1 | Engine switched to transmit mode |
| irq | output | 1 | Interrupt, set while ackReq or addrNack is 1 |

## Verification
A sequencer that is in the wrong phase shows up on the bus within one half bit period. The target model would then record a missing START or STOP, a wrong address bit or a wrong acknowledge level. A shift register or bit counter that is off by one gives a wrong rxData the moment ackReq rises, and the scoreboard compares that byte against its queue at that point. A flag that does not clear shows up right away, either as SCL staying low with busy never falling or as txMode still being set when the transfer has ended.

// File: rtl/mrx_pkg.sv
package mrx_pkg;
  localparam int MRX_BYTE_W = 8;
  localparam int MRX_ADDR_W = MRX_BYTE_W - 1;
  localparam int MRX_BIT_W  = $clog2(MRX_BYTE_W);

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_BLOW, S_BHIGH, S_AALOW, S_AAHIGH, S_NWAIT,
    S_HOLD, S_MALOW, S_MAHIGH, S_PLOW, S_PHIGH, S_PREL
  } mrxState_t;

  typedef struct packed {
    logic phaseStart;
    logic loadAddr;
    logic shiftEn;
    logic bitClr;
    logic loadRx;
  } mrxStrobe_t;
endpackage

// File: rtl/mrx_datapath.sv
module mrx_datapath
  import mrx_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  mrxStrobe_t            stb,
  input  logic [MRX_ADDR_W-1:0] slaveAddr,
  input  logic                  sdaIn,
  output logic                  tick,
  output logic                  lastBit,
  output logic                  txBit,
  output logic [MRX_BYTE_W-1:0] rxData
);
  localparam int CNT_W = $clog2(HALF_DIV + 1);

  logic [CNT_W-1:0]      divCnt;
  logic [MRX_BYTE_W-1:0] shiftReg;
  logic [MRX_BIT_W-1:0]  bitCnt;

  assign tick    = (divCnt == CNT_W'(HALF_DIV - 1));
  assign lastBit = (bitCnt == MRX_BIT_W'(MRX_BYTE_W - 1));
  assign txBit   = shiftReg[MRX_BYTE_W-1];

  // half-period timer, restarted on every phase change
  always_ff @(posedge clk) begin
    if (!rstN)               divCnt <= '0;
    else if (stb.phaseStart) divCnt <= '0;
    else if (!tick)          divCnt <= divCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
      rxData   <= '0;
    end else begin
      if (stb.loadAddr)     shiftReg <= {slaveAddr, 1'b1};
      else if (stb.shiftEn) shiftReg <= {shiftReg[MRX_BYTE_W-2:0], sdaIn};
      if (stb.bitClr)       bitCnt <= '0;
      else if (stb.shiftEn) bitCnt <= bitCnt + 1'b1;
      if (stb.loadRx)       rxData <= {shiftReg[MRX_BYTE_W-2:0], sdaIn};
    end
  end
endmodule

// File: rtl/mrx_control.sv
module mrx_control
  import mrx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWr,
  input  logic       ctrlSta,
  input  logic       ctrlSto,
  input  logic       ctrlAck,
  input  logic       dataWr,
  input  logic       sdaIn,
  input  logic       tick,
  input  logic       lastBit,
  input  logic       txBit,
  output mrxStrobe_t stb,
  output logic       sclOe,
  output logic       sdaOe,
  output logic       ackReq,
  output logic       addrNack,
  output logic       busy,
  output logic       txMode
);
  mrxState_t state, nextState;
  logic isAddr, ackBit, stopPend;

  always_comb begin
    nextState = state;
    stb       = '0;
    case (state)
      S_IDLE:   if (ctrlWr && ctrlSta) begin
                  nextState    = S_START;
                  stb.loadAddr = 1'b1;
                end
      S_START:  if (tick) begin
                  nextState  = S_BLOW;
                  stb.bitClr = 1'b1;
                end
      S_BLOW:   if (tick) nextState = S_BHIGH;
      S_BHIGH:  if (tick) begin
                  stb.shiftEn = 1'b1;
                  if (!lastBit)    nextState = S_BLOW;
                  else if (isAddr) nextState = S_AALOW;
                  else begin
                    nextState  = S_HOLD;
                    stb.loadRx = 1'b1;
                  end
                end
      S_AALOW:  if (tick) nextState = S_AAHIGH;
      S_AAHIGH: if (tick) begin
                  if (sdaIn) nextState = S_NWAIT;
                  else begin
                    nextState  = S_BLOW;
                    stb.bitClr = 1'b1;
                  end
                end
      S_NWAIT:  if (ctrlWr && ctrlSto) nextState = S_PLOW;
      S_HOLD:   if (ctrlWr) nextState = S_MALOW;
      S_MALOW:  if (tick) nextState = S_MAHIGH;
      S_MAHIGH: if (tick) begin
                  if (stopPend) nextState = S_PLOW;
                  else begin
                    nextState  = S_BLOW;
                    stb.bitClr = 1'b1;
                  end
                end
      S_PLOW:   if (tick) nextState = S_PHIGH;
      S_PHIGH:  if (tick) nextState = S_PREL;
      S_PREL:   if (tick) nextState = S_IDLE;
      default:  nextState = S_IDLE;
    endcase
    stb.phaseStart = (nextState != state);
  end

  always_comb begin
    sclOe = 1'b0;
    sdaOe = 1'b0;
    case (state)
      S_START:           sdaOe = 1'b1;
      S_BLOW:  begin     sclOe = 1'b1; sdaOe = isAddr & ~txBit; end
      S_BHIGH:           sdaOe = isAddr & ~txBit;
      S_AALOW, S_NWAIT, S_HOLD: sclOe = 1'b1;
      S_MALOW: begin     sclOe = 1'b1; sdaOe = ackBit; end
      S_MAHIGH:          sdaOe = ackBit;
      S_PLOW:  begin     sclOe = 1'b1; sdaOe = 1'b1; end
      S_PHIGH:           sdaOe = 1'b1;
      default: ;
    endcase
  end

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      isAddr   <= 1'b0;
      ackReq   <= 1'b0;
      addrNack <= 1'b0;
      ackBit   <= 1'b0;
      stopPend <= 1'b0;
      txMode   <= 1'b0;
    end else begin
      state <= nextState;
      if (state == S_IDLE && nextState == S_START) isAddr <= 1'b1;
      else if (state == S_AAHIGH && tick)          isAddr <= 1'b0;
      if (state == S_BHIGH && tick && lastBit && !isAddr) ackReq <= 1'b1;
      else if (state == S_HOLD && ctrlWr)                 ackReq <= 1'b0;
      if (state == S_AAHIGH && tick && sdaIn)            addrNack <= 1'b1;
      else if (state == S_NWAIT && ctrlWr && ctrlSto)    addrNack <= 1'b0;
      if (state == S_HOLD && ctrlWr) begin
        ackBit   <= ctrlAck;
        stopPend <= ctrlSto;
      end
      if (state == S_PREL && tick)            txMode <= 1'b0;
      else if (dataWr && state != S_IDLE)     txMode <= 1'b1;
    end
  end
endmodule

// File: rtl/i2c_rx_master.sv
module i2c_rx_master
  import mrx_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  ctrlWr,
  input  logic                  ctrlSta,
  input  logic                  ctrlSto,
  input  logic                  ctrlAck,
  input  logic [MRX_ADDR_W-1:0] slaveAddr,
  input  logic                  dataWr,
  input  logic                  sdaIn,
  output logic                  sclOe,
  output logic                  sdaOe,
  output logic [MRX_BYTE_W-1:0] rxData,
  output logic                  ackReq,
  output logic                  addrNack,
  output logic                  busy,
  output logic                  txMode,
  output logic                  irq
);
  mrxStrobe_t stb;
  logic tick, lastBit, txBit;

  mrx_control u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlSta(ctrlSta),
    .ctrlSto(ctrlSto), .ctrlAck(ctrlAck), .dataWr(dataWr), .sdaIn(sdaIn),
    .tick(tick), .lastBit(lastBit), .txBit(txBit), .stb(stb),
    .sclOe(sclOe), .sdaOe(sdaOe), .ackReq(ackReq), .addrNack(addrNack),
    .busy(busy), .txMode(txMode)
  );

  mrx_datapath #(.HALF_DIV(HALF_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .slaveAddr(slaveAddr),
    .sdaIn(sdaIn), .tick(tick), .lastBit(lastBit), .txBit(txBit),
    .rxData(rxData)
  );

  assign irq = ackReq | addrNack;
endmodule

// File: rtl/mrx_checker.sv
module mrx_checker (
  input logic       clk,
  input logic       rstN,
  input logic       ctrlWr,
  input logic       sdaIn,
  input logic       sclOe,
  input logic [7:0] rxData,
  input logic       ackReq,
  input logic       addrNack,
  input logic       busy,
  input logic       txMode
);
  p_flags_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(ackReq && addrNack));

  p_rx_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ackReq && $past(ackReq)) |-> $stable(rxData));

  p_scl_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    ackReq |-> sclOe);

  p_ack_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ackReq && ctrlWr) |=> !ackReq);

  p_stop_end_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($past(sdaIn) && !$past(sclOe)));

  p_tx_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !txMode);
endmodule

bind i2c_rx_master mrx_checker u_chk (
  .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .sdaIn(sdaIn), .sclOe(sclOe),
  .rxData(rxData), .ackReq(ackReq), .addrNack(addrNack), .busy(busy),
  .txMode(txMode)
);

// File: tb/test_i2c_rx_master.sv
`timescale 1ns/1ps
module test_i2c_rx_master;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlWr = 1'b0, ctrlSta = 1'b0, ctrlSto = 1'b0, ctrlAck = 1'b0;
  logic [6:0] slaveAddr = 7'h00;
  logic dataWr = 1'b0;
  logic sclOe, sdaOe, ackReq, addrNack, busy, txMode, irq;
  logic [7:0] rxData;
  logic slvDrive = 1'b0;
  logic sclLine, sdaLine;

  assign sclLine = ~sclOe;
  assign sdaLine = ~(sdaOe | slvDrive);

  always #2.5 clk = ~clk;

  i2c_rx_master #(.HALF_DIV(HALF)) i_i2c_rx_master (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlSta(ctrlSta),
    .ctrlSto(ctrlSto), .ctrlAck(ctrlAck), .slaveAddr(slaveAddr),
    .dataWr(dataWr), .sdaIn(sdaLine), .sclOe(sclOe), .sdaOe(sdaOe),
    .rxData(rxData), .ackReq(ackReq), .addrNack(addrNack), .busy(busy),
    .txMode(txMode), .irq(irq)
  );

  int nChecks = 0, nErrors = 0;
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- target model ----------------
  logic [6:0] tgtAddr = 7'h2A;
  logic [7:0] mem [0:3];
  int memN = 0;
  int c = 0, startCnt = 0, stopCnt = 0, highCnt = 0, lastHigh = 0;
  bit active = 0, done = 0, prevScl = 1, prevSda = 1;
  logic [7:0] gotAddr = 8'h00;
  bit ackSeen [0:3];

  always @(negedge clk) begin
    if (!rstN) begin
      slvDrive = 1'b0; active = 0; prevScl = 1; prevSda = 1;
    end else begin
      if (sclLine) highCnt++;
      if (sclLine && prevScl && prevSda && !sdaLine) begin
        active = 1; c = 0; done = 0; startCnt++; slvDrive = 1'b0;
      end else if (sclLine && prevScl && !prevSda && sdaLine) begin
        active = 0; stopCnt++; slvDrive = 1'b0;
      end else if (active) begin
        if (!prevScl && sclLine) begin
          c++;
          if (c <= 8) gotAddr = {gotAddr[6:0], sdaLine};
          if (c >= 18 && c % 9 == 0) begin
            ackSeen[c/9-2] = !sdaLine;
            if (sdaLine) done = 1;
          end
        end
        if (prevScl && !sclLine) begin
          if (c >= 10) lastHigh = highCnt;
          if (c / 9 == 0) begin
            if (c % 9 == 8 && gotAddr[7:1] == tgtAddr && gotAddr[0]) slvDrive = 1'b1;
            else begin
              slvDrive = 1'b0;
              if (c % 9 == 8) done = 1;
            end
          end else if (c % 9 < 8 && !done && (c/9 - 1) < memN)
            slvDrive = ~mem[c/9-1][7 - c%9];
          else slvDrive = 1'b0;
        end
      end
      if (!sclLine) highCnt = 0;
      prevScl = sclLine; prevSda = sdaLine;
    end
  end

  // ---------------- scoreboard ----------------
  logic [7:0] expQ [$];
  bit prevAckReq = 0;
  always @(negedge clk) begin
    if (rstN && ackReq && !prevAckReq) begin
      if (expQ.size() == 0) check(0, "R4 unexpected byte", rxData, 0);
      else begin
        logic [7:0] e;
        e = expQ.pop_front();
        check(rxData == e, "R4 rxData", rxData, e);
        check(irq == 1'b1, "R5 irq with ackReq", irq, 1);
      end
    end
    prevAckReq = ackReq;
  end

  task automatic ctrlWrite(input bit sta, input bit sto, input bit ack);
    @(negedge clk);
    ctrlWr = 1; ctrlSta = sta; ctrlSto = sto; ctrlAck = ack;
    @(negedge clk);
    ctrlWr = 0; ctrlSta = 0; ctrlSto = 0; ctrlAck = 0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  // driver: loads the target, pushes expected bytes, answers each byte
  task automatic readTxn(input int n, input bit pokeData);
    int stops0;
    stops0 = stopCnt;
    slaveAddr = tgtAddr;
    memN = n;
    for (int i = 0; i < n; i++) expQ.push_back(mem[i]);
    ctrlWrite(1, 0, 0);
    check(busy == 1'b1, "R2 busy after start", busy, 1);
    for (int i = 0; i < n; i++) begin
      while (!ackReq) @(negedge clk);
      if (i == 0) begin
        bit held;
        held = 1;
        for (int k = 0; k < 20; k++) begin
          @(negedge clk);
          if (!sclOe) held = 0;
        end
        check(held, "R5 SCL held low during ackReq", held, 1);
        if (pokeData) begin
          @(negedge clk) dataWr = 1;
          @(negedge clk) dataWr = 0;
          check(txMode == 1'b1, "R10 txMode after busy dataWr", txMode, 1);
        end
      end
      ctrlWrite(0, i == n-1, i != n-1);
      check(ackReq == 1'b0, "R6 ackReq cleared", ackReq, 0);
    end
    waitIdle();
    check(stopCnt == stops0 + 1, "R8 STOP seen", stopCnt, stops0 + 1);
    check(gotAddr == {tgtAddr, 1'b1}, "R2 address byte", gotAddr, {tgtAddr, 1'b1});
    for (int i = 0; i < n; i++)
      check(ackSeen[i] == (i != n-1), "R6 ack level per byte", ackSeen[i], i != n-1);
    check(expQ.size() == 0, "R7 all bytes received", expQ.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nErrors++; nChecks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check({sclOe, sdaOe, busy, ackReq, addrNack, txMode, irq} == 7'b0,
          "R1 reset outputs", {sclOe, sdaOe, busy, ackReq, addrNack, txMode, irq}, 0);

    // R10 dataWr while idle ignored
    @(negedge clk) dataWr = 1;
    @(negedge clk) dataWr = 0;
    check(txMode == 1'b0, "R10 idle dataWr ignored", txMode, 0);

    // single byte, NACK + STOP
    mem[0] = 8'hA5;
    readTxn(1, 0);
    check(startCnt == 1, "R2 START seen", startCnt, 1);
    check(lastHigh == HALF, "R9 SCL high width", lastHigh, HALF);

    // three bytes incl. all-ones and all-zeros, with a data write mid-transfer
    mem[0] = 8'h3C; mem[1] = 8'hFF; mem[2] = 8'h00;
    readTxn(3, 1);
    check(txMode == 1'b0, "R10 txMode cleared at end", txMode, 0);
    check(startCnt == 2, "R7 one START per transfer", startCnt, 2);

    // address not acknowledged
    begin
      int stops0;
      stops0 = stopCnt;
      slaveAddr = 7'h13;
      ctrlWrite(1, 0, 0);
      while (!addrNack && busy) @(negedge clk);
      check(addrNack == 1'b1, "R3 addrNack set", addrNack, 1);
      check(irq == 1'b1 && ackReq == 1'b0, "R3 irq without ackReq", {irq, ackReq}, 2'b10);
      repeat (12) @(negedge clk);
      check(sclOe == 1'b1 && busy == 1'b1, "R3 bus held", {sclOe, busy}, 2'b11);
      ctrlWrite(0, 1, 0);
      check(addrNack == 1'b0, "R3 addrNack cleared", addrNack, 0);
      waitIdle();
      check(stopCnt == stops0 + 1, "R3 STOP after address NACK", stopCnt, stops0 + 1);
    end

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule